// File: doc/BRIEF.md
# Split-Sector Hamming Parity Generator

This block sits on the byte-wide data path of a flash controller. While a 512-byte sector moves through that path, it builds two independent single-error-correcting Hamming codes, one for the first 256 bytes and one for the second 256 bytes. A host selects what the block does by writing an 8-bit mode code: one code clears the accumulators, one starts accumulation, and one turns the data register into a window on the finished parity. The host reads that window as three 16-bit words and uses the six parity bytes to correct up to one bit in each half, two bits per sector in all. The correction itself is done by the host.

Each half yields 16 line-parity bits, which come from the parity of each byte and its 8-bit address within the half, and 6 column-parity bits, which come from the bit positions within the bytes. Both halves are packed into the three result words in a fixed interleaved order.

Top module: `split_sector_ecc`

## Requirements
- R1: After reset the block is idle, all accumulators and the byte count are zero, and `rd_word` reads 0.
- R2: A `mode_wr` with `mode_code` 0xF4 clears both halves' line and column parity, sets the byte count to zero and enters the clear mode.
- R3: In calculate mode (entered by code 0xB4, without clearing) each `data_xfer` byte of parity p toggles line bit LP(2i) by p when bit i of its in-half address is 0, or LP(2i+1) by p when that address bit is 1, for i = 0..7.
- R4: Column parity per half: CP0 over bits 0,2,4,6; CP1 over bits 1,3,5,7; CP2 over bits 0,1,4,5; CP3 over bits 2,3,6,7; CP4 over bits 0-3; CP5 over bits 4-7. The column byte is {CP5..CP0, 2'b11}.
- R5: A `data_xfer` outside calculate mode, including the dummy read that follows a clear, changes no parity bit.
- R6: Bytes 0-255 after a clear feed half 0, bytes 256-511 feed half 1, and later bytes are ignored.
- R7: Code 0xD4 enters result mode at word 0. Word 0 is {h0 LP7-0, h0 LP15-8}, word 1 is {h1 LP7-0, h0 column byte} and word 2 is {h1 column byte, h1 LP15-8}, with the high byte listed first. The words stay stable while no transfer occurs.
- R8: Each `data_xfer` in result mode moves to the next word, and the sequence wraps from word 2 back to word 0.
- R9: Any other mode code enters idle and keeps the parity. `rd_word` reads 0 in every mode except result mode.
- R10: When `mode_wr` and `data_xfer` occur in the same cycle, the mode write takes effect and the transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode code write strobe |
| mode_code | input | 8 | Mode code value |
| data_xfer | input | 1 | One byte moved through the data path (read or write) |
| data_byte | input | 8 | Byte being moved |
| rd_word | output | 16 | Current result word (0 outside result mode) |

## Verification
The bench targets the half boundary. It places a lone set bit at byte 256 and expects it to appear only in half 1. A design that is off by one there would leak that bit into half 0's code. Byte 512 and later bytes are driven to catch a counter that wraps and corrupts half 0. The dummy read after a clear, transfers made while idle, and a mode write in the same cycle as a transfer are all aimed at a design that accumulates in the wrong mode. Hand-computed result words for a single-bit sector expose any swapped byte in the interleaved order, and a fourth read checks that the word index wraps.

// File: rtl/split_sector_ecc.sv
module split_sector_ecc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [7:0]    mode_code,
  input  logic          data_xfer,
  input  logic [DW-1:0] data_byte,
  output logic [15:0]   rd_word
);
  localparam int AW = 8;
  localparam int HALF = 1 << AW;
  localparam int CW = AW + 2;
  localparam logic [CW-1:0] FULL = CW'(2 * HALF);
  localparam logic [7:0] C_CLR = 8'hF4, C_CALC = 8'hB4, C_RES = 8'hD4;

  typedef enum logic [1:0] {M_IDLE, M_CLR, M_CALC, M_RES} mode_t;

  mode_t          mode;
  logic [CW-1:0]  cnt;
  logic [1:0]     idx;
  logic [15:0]    lp [2];
  logic [5:0]     cp [2];
  logic [15:0]    lp_upd;
  logic [5:0]     cp_upd;
  logic           par;
  logic [AW-1:0]  addr;
  logic           half;
  logic           take;

  assign par  = ^data_byte;
  assign addr = cnt[AW-1:0];
  assign half = cnt[AW];
  assign take = data_xfer && !mode_wr && mode == M_CALC && cnt < FULL;

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      lp_upd[2*i]   = par & ~addr[i];
      lp_upd[2*i+1] = par &  addr[i];
    end
    cp_upd[0] = ^(data_byte & 8'h55);
    cp_upd[1] = ^(data_byte & 8'hAA);
    cp_upd[2] = ^(data_byte & 8'h33);
    cp_upd[3] = ^(data_byte & 8'hCC);
    cp_upd[4] = ^(data_byte & 8'h0F);
    cp_upd[5] = ^(data_byte & 8'hF0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      cnt  <= '0;
      idx  <= '0;
      lp[0] <= '0; lp[1] <= '0;
      cp[0] <= '0; cp[1] <= '0;
    end else if (mode_wr) begin
      case (mode_code)
        C_CLR: begin
          mode <= M_CLR;
          cnt  <= '0;
          lp[0] <= '0; lp[1] <= '0;
          cp[0] <= '0; cp[1] <= '0;
        end
        C_CALC: mode <= M_CALC;
        C_RES: begin
          mode <= M_RES;
          idx  <= '0;
        end
        default: mode <= M_IDLE;
      endcase
    end else if (take) begin
      lp[half] <= lp[half] ^ lp_upd;
      cp[half] <= cp[half] ^ cp_upd;
      cnt      <= cnt + 1'b1;
    end else if (data_xfer && mode == M_RES) begin
      idx <= (idx == 2'd2) ? 2'd0 : idx + 1'b1;
    end
  end

  logic [7:0] col0, col1;
  assign col0 = {cp[0], 2'b11};
  assign col1 = {cp[1], 2'b11};

  always_comb begin
    rd_word = '0;
    if (mode == M_RES) begin
      case (idx)
        2'd0:    rd_word = {lp[0][7:0], lp[0][15:8]};
        2'd1:    rd_word = {lp[1][7:0], col0};
        default: rd_word = {col1, lp[1][15:8]};
      endcase
    end
  end
endmodule

// File: rtl/split_sector_ecc_chk.sv
module split_sector_ecc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_wr,
  input logic [7:0]  mode_code,
  input logic        data_xfer,
  input logic [15:0] rd_word,
  input logic [1:0]  mode,
  input logic [9:0]  cnt,
  input logic [15:0] lp0,
  input logic [15:0] lp1,
  input logic [5:0]  cp0,
  input logic [5:0]  cp1
);
  AST_CLEAR_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_code == 8'hF4 |=> lp0 == '0 && lp1 == '0 && cp0 == '0 && cp1 == '0 && cnt == '0); // R2

  AST_HOLD_OUTSIDE_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr && mode != 2'd2 |=> $stable(lp0) && $stable(lp1) && $stable(cp0) && $stable(cp1)); // R5

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 10'd512); // R6

  AST_HALF1_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr && cnt < 10'd256 |=> $stable(lp1) && $stable(cp1)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3 |-> rd_word == 16'h0); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && data_xfer && mode_code != 8'hF4 |=> $stable(cnt) && $stable(lp0) && $stable(lp1)); // R10
endmodule

bind split_sector_ecc split_sector_ecc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
  .data_xfer(data_xfer), .rd_word(rd_word), .mode(mode), .cnt(cnt),
  .lp0(lp[0]), .lp1(lp[1]), .cp0(cp[0]), .cp1(cp[1])
);

// File: tb/tb_split_sector_ecc.sv
`timescale 1ns/1ps
module tb_split_sector_ecc;
  logic clk = 0, rst_n = 0;
  logic mode_wr = 0, data_xfer = 0;
  logic [7:0] mode_code = 0, data_byte = 0;
  logic [15:0] rd_word;
  int total = 0, bad = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  split_sector_ecc dut (.clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .data_xfer(data_xfer), .data_byte(data_byte), .rd_word(rd_word));

  logic [15:0] mlp [2];
  logic [5:0]  mcp [2];
  int mcnt, midx, mmode;

  function automatic logic [15:0] mword();
    logic [7:0] c0, c1;
    c0 = {mcp[0], 2'b11};
    c1 = {mcp[1], 2'b11};
    if (mmode != 3) return 16'h0;
    if (midx == 0) return {mlp[0][7:0], mlp[0][15:8]};
    if (midx == 1) return {mlp[1][7:0], c0};
    return {c1, mlp[1][15:8]};
  endfunction

  task automatic model(input bit mw, input logic [7:0] code, input bit xf, input logic [7:0] b);
    if (mw) begin
      if (code == 8'hF4) begin
        mmode = 1; mcnt = 0;
        mlp[0] = 0; mlp[1] = 0; mcp[0] = 0; mcp[1] = 0;
      end else if (code == 8'hB4) mmode = 2;
      else if (code == 8'hD4) begin mmode = 3; midx = 0; end
      else mmode = 0;
    end else if (xf && mmode == 2 && mcnt < 512) begin
      int h, a, p;
      h = mcnt / 256; a = mcnt % 256; p = 0;
      for (int j = 0; j < 8; j++) p ^= b[j];
      for (int i = 0; i < 8; i++) mlp[h][2*i + ((a >> i) & 1)] ^= p[0];
      for (int j = 0; j < 8; j++)
        if (b[j]) for (int k = 0; k < 3; k++) mcp[h][2*k + ((j >> k) & 1)] ^= 1'b1;
      mcnt++;
    end else if (xf && mmode == 3) midx = (midx + 1) % 3;
  endtask

  task automatic check(input logic [15:0] exp, input string req);
    total++;
    if (rd_word !== exp) begin
      bad++;
      $display("FAIL %s: rd_word=%h expected=%h", req, rd_word, exp);
    end
  endtask

  task automatic step(input bit mw, input logic [7:0] code, input bit xf, input logic [7:0] b);
    @(negedge clk);
    check(mword(), tag);
    mode_wr = mw; mode_code = code; data_xfer = xf; data_byte = b;
    model(mw, code, xf, b);
  endtask

  task automatic look(input logic [15:0] exp, input string req);
    @(negedge clk);
    check(exp, req);
    mode_wr = 0; data_xfer = 0;
  endtask

  task automatic wr(input logic [7:0] c); step(1, c, 0, 0); endtask
  task automatic xfer(input logic [7:0] b); step(0, 0, 1, b); endtask
  task automatic idle(); step(0, 0, 0, 0); endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mlp[0] = 0; mlp[1] = 0; mcp[0] = 0; mcp[1] = 0;
    mcnt = 0; midx = 0; mmode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(16'h0000, "R1");

    tag = "R5";
    wr(8'hF4); xfer(8'hFF); wr(8'hD4); look(16'h0000, "R5");
    tag = "R3";
    wr(8'hF4); xfer(8'hFF); wr(8'hB4); xfer(8'h01); wr(8'hD4);
    look(16'h5555, "R3");
    idle(); look(16'h5555, "R7");
    xfer(0); look(16'h0057, "R4");
    xfer(0); look(16'h0300, "R7");
    xfer(0); look(16'h5555, "R8");

    tag = "R6";
    wr(8'hF4); wr(8'hB4);
    for (int i = 0; i < 256; i++) xfer(8'h00);
    xfer(8'h80); wr(8'hD4);
    look(16'h0000, "R6");
    xfer(0); look(16'h5503, "R6");
    xfer(0); look(16'hAB55, "R4");

    tag = "R6";
    wr(8'hF4); wr(8'hB4);
    for (int i = 0; i < 532; i++) xfer(8'((i * 37 + 5) & 255));
    tag = "R7";
    wr(8'hD4);
    for (int i = 0; i < 7; i++) xfer(0);

    tag = "R9";
    wr(8'hF4); wr(8'hB4);
    for (int i = 0; i < 40; i++) xfer(8'(i * 11 + 3));
    wr(8'h94);
    for (int i = 0; i < 10; i++) xfer(8'hA5);
    look(16'h0000, "R9");
    wr(8'hB4);
    for (int i = 0; i < 20; i++) xfer(8'(i ^ 8'h3C));
    tag = "R10";
    step(1, 8'hB4, 1, 8'h01);
    step(1, 8'hD4, 1, 8'h00);
    for (int i = 0; i < 4; i++) xfer(0);
    tag = "R2";
    wr(8'hF4); wr(8'hD4);
    look(16'h0000, "R2");
    xfer(0); look(16'h0003, "R2");
    idle(); idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule